// File: doc/BRIEF.md
# Two-Phase Horizontal Shift Clock Generator

This block sequences one horizontal line of a bidirectional column scanner. It waits for a one-cycle line-start tick and raises a start pulse. It then runs a pair of complementary shift clocks. Every level of that pair addresses one group of six columns, which the column drivers sample together. A group index tells downstream logic which group is live, and a done flag marks the end of the line. Both shift clocks are divided down from a reference clock.

The scan direction is sampled on the line-start tick. Right scan numbers the groups upward from zero. Left scan numbers them downward from the last group. Between lines both clocks stay parked, with the first clock low and the second clock high, so the scanner never sees a stray edge. The start pulse straddles the first rising edge of the first clock. Its lead before that edge and its trail after it are parameters, so they can be set to the set-up and hold the scanner needs (about 100 ns each at a 2.5 MHz shift clock).

Top module: `hclk_gen`

## Requirements
- R1: `hck1` and `hck2` are complements on every cycle. Outside a line, `hck1` is 0 and `hck2` is 1.
- R2: During a line, each level of `hck1` lasts exactly DIV/2 reference cycles. DIV is even.
- R3: Take a line-start tick sampled while idle at clock edge e0. `hst` is 1 from edge e0 on. `hck1` stays low for HST_LEAD further edges and first rises at edge e0+HST_LEAD.
- R4: `hst` falls HST_TRAIL cycles after the first rise of `hck1`, while `hck1` is still high (HST_TRAIL < DIV/2).
- R5: A line has exactly NUM_GROUPS clock levels, so `hck1` rises NUM_GROUPS/2 times. NUM_GROUPS is even.
- R6: With `scan_right` = 1 at the tick, `grp_idx` is 0 during the first level and increases by 1 at each clock transition, ending at NUM_GROUPS-1.
- R7: With `scan_right` = 0 at the tick, `grp_idx` is NUM_GROUPS-1 during the first level and decreases by 1 at each transition, ending at 0.
- R8: A change of `scan_right` during a line does not affect that line's index sequence.
- R9: `line_done` is 1 for exactly one cycle. It rises at the edge where the last level ends, and the clocks return to their parked levels at that same edge.
- R10: A line-start tick that arrives during a line is ignored.
- R11: After synchronous reset, `hst` = 0, `line_done` = 0, `grp_idx` = 0, `hck1` = 0 and `hck2` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle tick that starts a line |
| scan_right | input | 1 | 1 = right scan, 0 = left scan, sampled on the tick |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | First shift clock |
| hck2 | output | 1 | Second shift clock, complement of hck1 |
| grp_idx | output | $clog2(NUM_GROUPS) | Index of the six-column group being addressed |
| line_done | output | 1 | One-cycle pulse after the final group |

## Verification
The bench builds the block with DIV = 4, NUM_GROUPS = 6, HST_LEAD = 1 and HST_TRAIL = 1. With these values a whole line lasts thirteen cycles. Every cycle of every line can then be compared against an expected waveform. Both ends of the index range are reached in each direction. The small sizes also let the bench place a mid-line direction flip and a stray tick at chosen cycles. They also let a reset land in the middle of a scan.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SCAN
    } seq_state_t;

    typedef struct packed {
        logic start;   // first hck1 rise of the line
        logic toggle;  // move to the next group
        logic finish;  // last level ends, park the clocks
    } seq_ev_t;

    function automatic int unsigned first_group(input logic right, input int unsigned n);
        return right ? 0 : n - 1;
    endfunction

endpackage

// File: rtl/hclk_seq.sv
module hclk_seq
    import hclk_pkg::*;
#(
    parameter int DIV        = 8,
    parameter int NUM_GROUPS = 108,
    parameter int HST_LEAD   = 2,
    parameter int HST_TRAIL  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    line_start,
    input  logic    scan_right,
    output seq_ev_t ev,
    output logic    busy,
    output logic    dir_q,
    output logic    hst,
    output logic    line_done
);
    localparam int HALF = DIV / 2;
    localparam int CMAX = (HALF > HST_LEAD) ? HALF : HST_LEAD;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int TW   = $clog2(NUM_GROUPS);

    seq_state_t      state;
    logic [CW-1:0]   cnt;
    logic [TW-1:0]   tr;
    logic            half_end;

    always_comb begin
        half_end  = (state == SEQ_SCAN) && (cnt == CW'(HALF - 1));
        ev.start  = (state == SEQ_LEAD) && (cnt == CW'(HST_LEAD - 1));
        ev.finish = half_end && (tr == TW'(NUM_GROUPS - 1));
        ev.toggle = half_end && (tr != TW'(NUM_GROUPS - 1));
        busy      = (state != SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            cnt       <= '0;
            tr        <= '0;
            hst       <= 1'b0;
            dir_q     <= 1'b1;
            line_done <= 1'b0;
        end else begin
            line_done <= ev.finish;
            case (state)
                SEQ_IDLE: begin
                    if (line_start) begin
                        state <= SEQ_LEAD;
                        cnt   <= '0;
                        hst   <= 1'b1;
                        dir_q <= scan_right;
                    end
                end
                SEQ_LEAD: begin
                    if (ev.start) begin
                        state <= SEQ_SCAN;
                        cnt   <= '0;
                        tr    <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_SCAN: begin
                    if (tr == '0 && cnt == CW'(HST_TRAIL - 1))
                        hst <= 1'b0;
                    if (half_end) begin
                        cnt <= '0;
                        if (ev.finish) state <= SEQ_IDLE;
                        else           tr    <= tr + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done);  // R9

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({ev.start, ev.toggle, ev.finish}) <= 1);  // R5

endmodule

// File: rtl/hclk_phase.sv
module hclk_phase
    import hclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_ev_t ev,
    input  logic    busy,
    output logic    hck1,
    output logic    hck2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hck1 <= 1'b0;
            hck2 <= 1'b1;
        end else if (ev.start) begin
            hck1 <= 1'b1;
            hck2 <= 1'b0;
        end else if (ev.toggle) begin
            hck1 <= ~hck1;
            hck2 <= ~hck2;
        end else if (ev.finish) begin
            hck1 <= 1'b0;
            hck2 <= 1'b1;
        end
    end

    AST_CLK_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        hck1 != hck2);  // R1

    AST_PARKED_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!hck1 && hck2));  // R1

endmodule

// File: rtl/hclk_group.sv
module hclk_group
    import hclk_pkg::*;
#(
    parameter int NUM_GROUPS = 108,
    localparam int GW        = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_ev_t       ev,
    input  logic          dir,
    output logic [GW-1:0] grp_idx
);
    always_ff @(posedge clk) begin
        if (rst)
            grp_idx <= '0;
        else if (ev.start)
            grp_idx <= GW'(first_group(dir, NUM_GROUPS));
        else if (ev.toggle)
            grp_idx <= dir ? grp_idx + 1'b1 : grp_idx - 1'b1;
    end

    AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(grp_idx) < NUM_GROUPS);  // R6

endmodule

// File: rtl/hclk_gen.sv
module hclk_gen
    import hclk_pkg::*;
#(
    parameter int DIV        = 8,
    parameter int NUM_GROUPS = 108,
    parameter int HST_LEAD   = 2,
    parameter int HST_TRAIL  = 2,
    localparam int GW        = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          scan_right,
    output logic          hst,
    output logic          hck1,
    output logic          hck2,
    output logic [GW-1:0] grp_idx,
    output logic          line_done
);
    localparam int HALF = DIV / 2;
    localparam int RW   = $clog2(2 * DIV + 1);

    seq_ev_t ev;
    logic    busy;
    logic    dir_q;

    hclk_seq #(
        .DIV(DIV), .NUM_GROUPS(NUM_GROUPS), .HST_LEAD(HST_LEAD), .HST_TRAIL(HST_TRAIL)
    ) i_seq (
        .clk(clk), .rst(rst), .line_start(line_start), .scan_right(scan_right),
        .ev(ev), .busy(busy), .dir_q(dir_q), .hst(hst), .line_done(line_done)
    );

    hclk_phase i_phase (
        .clk(clk), .rst(rst), .ev(ev), .busy(busy), .hck1(hck1), .hck2(hck2)
    );

    hclk_group #(.NUM_GROUPS(NUM_GROUPS)) i_group (
        .clk(clk), .rst(rst), .ev(ev), .dir(dir_q), .grp_idx(grp_idx)
    );

    // Level-length watch: cycles since hck1 last changed, saturating.
    logic          hck1_d;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hck1_d  <= 1'b0;
            run_len <= '0;
        end else begin
            hck1_d <= hck1;
            if (hck1 != hck1_d)
                run_len <= RW'(1);
            else if (run_len != RW'(2 * DIV))
                run_len <= run_len + 1'b1;
        end
    end

    AST_HALF_MAX: assert property (@(posedge clk) disable iff (rst)
        (busy && !hst) |-> (int'(run_len) <= HALF));  // R2

    AST_HST_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(hst) |-> (!hck1 && hck2));  // R3

    AST_HST_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(hst) |-> hck1);  // R4

    AST_DONE_PARKED: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (!hck1 && hck2 && !hst));  // R9

endmodule

// File: tb/test_hclk_gen.sv
`timescale 1ns/1ps
module test_hclk_gen;
    localparam int DIV   = 4;
    localparam int NG    = 6;
    localparam int LEAD  = 1;
    localparam int TRAIL = 1;
    localparam int HALF  = DIV / 2;
    localparam int ENDK  = LEAD + NG * HALF;
    localparam int GW    = $clog2(NG);

    typedef struct packed {
        logic       dir;
        logic       flip;
        logic       extra;
        logic [7:0] last;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b0, 8'(NG - 1)},
        '{1'b0, 1'b0, 1'b0, 8'd0},
        '{1'b1, 1'b1, 1'b0, 8'(NG - 1)},
        '{1'b0, 1'b1, 1'b0, 8'd0},
        '{1'b1, 1'b0, 1'b1, 8'(NG - 1)},
        '{1'b0, 1'b1, 1'b1, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_start = 1'b0;
    logic          scan_right = 1'b1;
    logic          hst, hck1, hck2, line_done;
    logic [GW-1:0] grp_idx;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hclk_gen #(.DIV(DIV), .NUM_GROUPS(NG), .HST_LEAD(LEAD), .HST_TRAIL(TRAIL)) i_hclk_gen (
        .clk(clk), .rst(rst), .line_start(line_start), .scan_right(scan_right),
        .hst(hst), .hck1(hck1), .hck2(hck2), .grp_idx(grp_idx), .line_done(line_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int outs(input logic a, input logic b, input logic c, input logic d);
        return int'({a, b, c, d});
    endfunction

    task automatic run_line(input vec_t v);
        int   rises = 0;
        logic prev  = 1'b0;
        string itag;
        itag = v.extra ? "R10" : (v.flip ? "R8" : (v.dir ? "R6" : "R7"));
        @(negedge clk);
        line_start = 1'b1;
        scan_right = v.dir;
        for (int k = 0; k <= ENDK + 1; k++) begin
            int   g;
            logic h_e, c_e;
            string tag;
            @(negedge clk);
            line_start = (v.extra && k == LEAD + 2);
            if (v.flip && k == LEAD + HALF) scan_right = !v.dir;
            h_e = (k < LEAD + TRAIL);
            c_e = 1'b0;
            if (k >= LEAD && k < ENDK) begin
                g   = (k - LEAD) / HALF;
                c_e = (g % 2 == 0);
                check(itag, int'(grp_idx), v.dir ? g : NG - 1 - g);
            end
            tag = (k < LEAD) ? "R1/R3" : (k < LEAD + TRAIL) ? "R1/R4" :
                  (k == ENDK) ? "R1/R9" : "R1/R2";
            check(tag, outs(hst, hck1, hck2, line_done), outs(h_e, c_e, !c_e, k == ENDK));
            if (hck1 && !prev) rises++;
            prev = hck1;
        end
        check("R5", rises, NG / 2);
        check(itag, int'(grp_idx), int'(v.last));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11", outs(hst, hck1, hck2, line_done), outs(1'b0, 1'b0, 1'b1, 1'b0));
        check("R11", int'(grp_idx), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", outs(hst, hck1, hck2, line_done), outs(1'b0, 1'b0, 1'b1, 1'b0));

        foreach (VECS[i]) begin
            run_line(VECS[i]);
            repeat (3) @(negedge clk);
            check("R1", outs(hst, hck1, hck2, line_done), outs(1'b0, 1'b0, 1'b1, 1'b0));
        end

        // Reset in mid-scan returns everything to the reset state.
        line_start = 1'b1;
        scan_right = 1'b0;
        @(negedge clk);
        line_start = 1'b0;
        repeat (LEAD + 3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11", outs(hst, hck1, hck2, line_done), outs(1'b0, 1'b0, 1'b1, 1'b0));
        check("R11", int'(grp_idx), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // After the reset a full right-scan line still runs correctly.
        run_line(VECS[0]);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule